// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that needs no idle cycles between reads and writes. A controller drives address, control and byte enables, and the block samples them on each rising clock edge. Write data comes later than its address: one edge later in flow-through mode and two edges later in pipelined mode. Reads appear on the output either in the cycle right after the sampling edge (flow-through) or one edge after that (pipelined). Because of this write lag, any sequence of reads and writes can use the bus on every cycle.

A small buffer of accepted writes whose data has not yet reached the array lets a read that hits one of those addresses return the newer bytes. A two-bit burst counter steps through the low address bits in linear or interleaved order when the advance input is held. Three chip enables gate new accesses. An output enable and a sleep input shut off the output drivers without waiting for the clock.

Top module: `zbt_sram`

## Requirements
- R1: With `pipe_mode`=0, a read sampled at edge N drives its word on `dq_out` with `dq_oe`=1 from just after edge N until edge N+1, and `dq_oe` falls again if no read was sampled at edge N+1.
- R2: With `pipe_mode`=1, a read sampled at edge N drives its word from just after edge N+1, so the first word of a burst takes one extra cycle and each later beat follows one cycle apart.
- R3: Write data on `din` is taken at the edge after the write address when `pipe_mode`=0, and two edges after it when `pipe_mode`=1. `din` at the other edges has no effect on that write.
- R4: A read whose address matches an accepted write whose data has not yet been stored returns that write's enabled bytes, with the remaining bytes taken from the array. Reads and writes may alternate on consecutive cycles.
- R5: `bw_n[i]`=0 enables byte i, bits [9i+8:9i], of a write. Bytes whose enable is 1 keep their old contents.
- R6: A new access is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 with `adv`=0. Otherwise nothing is written, and no data is driven in that access's output slot.
- R7: `oe_n`=1 forces `dq_out` to high impedance and `dq_oe` to 0 at once, without a clock edge. Lowering it during a read output slot drives the word at once.
- R8: While `sleep`=1, `dq_out` is high impedance and sampled commands are ignored. Memory contents are kept.
- R9: `adv`=1 after an accepted access continues the burst with the same operation, ignoring the chip enables and `we_n`. With `ilv_order`=0 the two low address bits of beat k are (start+k) mod 4, and the upper address bits are unchanged.
- R10: With `ilv_order`=1 the two low address bits of beat k are start XOR k.
- R11: After synchronous reset `dq_oe`=0 and `dq_out` is high impedance, and `adv`=1 with no burst loaded performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| ilv_order | input | 1 | Static: 1 interleaved burst, 0 linear |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue current burst |
| we_n | input | 1 | 0 write, 1 read (on a new access) |
| bw_n | input | BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down, active high |
| dq_out | output | BYTES*BYTE_W | Read data, high impedance when not driven |
| dq_oe | output | 1 | 1 while `dq_out` is driven |

## Verification
A wrong pending-write entry shows up as stale or mixed bytes on the first read that follows the write. In flow-through mode that read's slot opens right after its sampling edge, and in pipelined mode one edge later. A wrong burst counter puts a word at the wrong address, which shows when that address is later read alone, or right away as a wrong beat in a read burst. A stage valid bit stuck high shows as `dq_oe` high in a slot with no read. A lag off by one edge stores the `din` value of the neighbouring cycle, so the bench drives a different word on each candidate edge.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  // Offset of a burst beat within its four-word group.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zbt_burst.sv
module zbt_burst #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_now
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;

  assign beat_nx = beat_q + 2'd1;

  always_comb begin
    if (load) addr_now = addr_in;
    else      addr_now = {base_q[ADDR_W-1:2],
                          zbt_pkg::burst_offset(base_q[1:0], beat_nx, ilv)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_nx;
    end
  end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES-1:0]        wbe,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = BYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Byte-enabled write port.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wbe[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  // Registered read port, old data on a same-edge collision.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    ilv_order,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [BYTES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = BYTES * BYTE_W;

  // ---------------- command acceptance ----------------
  logic chip_sel, take_new, take_cont, acc, acc_wr;
  logic burst_live_q, last_wr_q;
  logic [ADDR_W-1:0] acc_addr;
  logic [BYTES-1:0]  acc_be;

  assign chip_sel  = ~ce1_n & ce2 & ~ce3_n;
  assign take_new  = ~sleep & ~adv & chip_sel;
  assign take_cont = ~sleep & adv & burst_live_q;
  assign acc       = take_new | take_cont;
  assign acc_wr    = take_new ? ~we_n : last_wr_q;
  assign acc_be    = ~bw_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_live_q <= 1'b0;
      last_wr_q    <= 1'b0;
    end else begin
      burst_live_q <= acc;
      if (take_new) last_wr_q <= ~we_n;
    end
  end

  zbt_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .load     (take_new),
    .step     (take_cont),
    .ilv      (ilv_order),
    .addr_in  (addr),
    .addr_now (acc_addr)
  );

  // ---------------- late-write address stages ----------------
  logic              s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= acc;
      s2_vld <= s1_vld;
    end
    s1_wr   <= acc_wr;
    s1_addr <= acc_addr;
    s1_be   <= acc_be;
    s2_wr   <= s1_wr;
    s2_addr <= s1_addr;
    s2_be   <= s1_be;
  end

  // Commit of the write whose data is on din now.
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [BYTES-1:0]  cm_be;

  always_comb begin
    if (pipe_mode) begin
      cm_en   = s2_vld & s2_wr;
      cm_addr = s2_addr;
      cm_be   = s2_be;
    end else begin
      cm_en   = s1_vld & s1_wr;
      cm_addr = s1_addr;
      cm_be   = s1_be;
    end
  end

  // ---------------- storage ----------------
  logic              rd_take;
  logic [DATA_W-1:0] ram_q;

  assign rd_take = acc & ~acc_wr;

  zbt_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk   (clk),
    .we    (cm_en),
    .waddr (cm_addr),
    .wbe   (cm_be),
    .wdata (din),
    .re    (rd_take),
    .raddr (acc_addr),
    .rdata (ram_q)
  );

  // ---------------- pending-write forwarding ----------------
  logic              r1_vld, r1_hit0, r1_hit1;
  logic [BYTES-1:0]  r1_be0, r1_be1;
  logic [DATA_W-1:0] r1_d0;

  always_ff @(posedge clk) begin
    if (rst) r1_vld <= 1'b0;
    else     r1_vld <= rd_take;
    r1_hit0 <= cm_en && (cm_addr == acc_addr);
    r1_be0  <= cm_be;
    r1_d0   <= din;
    r1_hit1 <= pipe_mode && s1_vld && s1_wr && (s1_addr == acc_addr);
    r1_be1  <= s1_be;
  end

  logic [DATA_W-1:0] rd1, out_nx, out_q;
  logic              out_vld;

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign rd1[b*BYTE_W +: BYTE_W] = (r1_hit0 && r1_be0[b]) ?
        r1_d0[b*BYTE_W +: BYTE_W] : ram_q[b*BYTE_W +: BYTE_W];
    assign out_nx[b*BYTE_W +: BYTE_W] = (r1_hit1 && r1_be1[b]) ?
        din[b*BYTE_W +: BYTE_W] : rd1[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= pipe_mode & r1_vld;
    out_q <= out_nx;
  end

  // ---------------- output drivers ----------------
  logic              slot_vld;
  logic [DATA_W-1:0] slot_data;

  assign slot_vld  = pipe_mode ? out_vld : r1_vld;
  assign slot_data = pipe_mode ? out_q : rd1;
  assign dq_oe     = slot_vld & ~oe_n & ~sleep;
  assign dq_out    = dq_oe ? slot_data : {DATA_W{1'bz}};

  // ---------------- assertions ----------------
  p_sel_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel && !adv) |=> !s1_vld)
    else $error("unselected cycle accepted");

  p_sleep_block_r8: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !s1_vld)
    else $error("command accepted during sleep");

  p_lag_r3: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && s1_vld && s1_wr) |=> (cm_en && cm_addr == $past(s1_addr)))
    else $error("pipelined write not committed two edges after address");

  p_pipe_out_r2: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && r1_vld) |=> out_vld)
    else $error("pipelined read slot missing");

  p_lin_step_r9: assert property (@(posedge clk) disable iff (rst)
    (take_cont && !ilv_order) |->
      (acc_addr[1:0] == s1_addr[1:0] + 2'd1 &&
       acc_addr[ADDR_W-1:2] == s1_addr[ADDR_W-1:2]))
    else $error("linear burst step wrong");

  p_hiz_r7: assert property (@(posedge clk) disable iff (rst)
    (oe_n || sleep) |-> !dq_oe)
    else $error("driving while disabled");

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dq_oe)
    else $error("output driven right after reset");

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pipe_mode = 1'b0, ilv_order = 1'b0;
  logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        adv = 1'b0, we_n = 1'b1;
  logic [1:0]  bw_n = 2'b00;
  logic [7:0]  addr = '0;
  logic [17:0] din = '0;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [17:0] dq_out;
  logic        dq_oe;
  logic [2:0]  ce_mask = 3'b111;

  int n_chk = 0, n_bad = 0;

  localparam int OP_IDLE = 0, OP_RD = 1, OP_WR = 2, OP_ADV = 3;
  localparam logic [17:0] DA = 18'h1_2345, DB = 18'h2_0F0F, DC = 18'h0_ABCD,
                          DD = 18'h3_1357, DE = 18'h2_4680, DF = 18'h3_FE01,
                          DG = 18'h0_1DB3, DH = 18'h1_5555, DX = 18'h3_3333;

  always #(CLK_P/2) clk = ~clk;

  zbt_sram uut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input int op, input logic [7:0] ad, input logic [1:0] bwn,
                       input logic [17:0] d);
    logic s;
    @(negedge clk);
    s     = (op == OP_RD) || (op == OP_WR);
    adv   = (op == OP_ADV);
    we_n  = (op != OP_WR);
    ce1_n = ~(s & ce_mask[0]);
    ce2   = s & ce_mask[1];
    ce3_n = ~(s & ce_mask[2]);
    addr  = ad;
    bw_n  = bwn;
    din   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic pm, input logic il);
    @(negedge clk);
    rst = 1'b1; pipe_mode = pm; ilv_order = il;
    adv = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk("R11 oe after reset", {17'd0, dq_oe}, 18'd0);
    chk("R11 hiz after reset", dq_out, 18'bz);
    drive(OP_ADV, 8'h10, 2'b00, DX);
    chk("R11 adv without burst", {17'd0, dq_oe}, 18'd0);
  endtask

  task automatic t_flow;
    drive(OP_WR, 8'h10, 2'b00, DX);
    drive(OP_RD, 8'h10, 2'b00, DA);
    chk("R4 flow read of pending write", dq_out, DA);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    chk("R1 slot closes", {17'd0, dq_oe}, 18'd0);
    drive(OP_RD, 8'h10, 2'b00, DX);
    chk("R1 flow read from array", dq_out, DA);
    drive(OP_WR, 8'h11, 2'b00, DX);
    drive(OP_IDLE, 8'h00, 2'b00, DB);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    drive(OP_RD, 8'h11, 2'b00, DX);
    chk("R3 flow single lag", dq_out, DB);
  endtask

  task automatic t_mask;
    drive(OP_WR, 8'h30, 2'b00, DX);
    drive(OP_WR, 8'h30, 2'b10, DF);
    drive(OP_RD, 8'h30, 2'b00, DG);
    chk("R5 masked forward", dq_out, {DF[17:9], DG[8:0]});
    drive(OP_RD, 8'h30, 2'b00, DX);
    chk("R5 masked array", dq_out, {DF[17:9], DG[8:0]});
  endtask

  task automatic t_ce;
    for (int i = 0; i < 3; i++) begin
      ce_mask = 3'b111 & ~(3'b001 << i);
      drive(OP_WR, 8'h30, 2'b00, DX);
      ce_mask = 3'b111;
      drive(OP_IDLE, 8'h00, 2'b00, DH);
      drive(OP_RD, 8'h30, 2'b00, DX);
      chk("R6 write blocked", dq_out, {DF[17:9], DG[8:0]});
      ce_mask = 3'b111 & ~(3'b001 << i);
      drive(OP_RD, 8'h30, 2'b00, DX);
      chk("R6 read blocked", {17'd0, dq_oe}, 18'd0);
      ce_mask = 3'b111;
    end
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    drive(OP_RD, 8'h10, 2'b00, DX);
    chk("R7 oe off", {17'd0, dq_oe}, 18'd0);
    chk("R7 oe off hiz", dq_out, 18'bz);
    oe_n = 1'b0;
    #1;
    chk("R7 oe async on", dq_out, DA);
    oe_n = 1'b1;
    #1;
    chk("R7 oe async off", dq_out, 18'bz);
    oe_n = 1'b0;
  endtask

  task automatic t_sleep;
    sleep = 1'b1;
    drive(OP_WR, 8'h10, 2'b00, DX);
    drive(OP_IDLE, 8'h00, 2'b00, DH);
    drive(OP_RD, 8'h10, 2'b00, DX);
    chk("R8 sleep hiz", dq_out, 18'bz);
    sleep = 1'b0;
    drive(OP_RD, 8'h10, 2'b00, DX);
    chk("R8 write ignored in sleep", dq_out, DA);
    sleep = 1'b1;
    #1;
    chk("R8 sleep async", {17'd0, dq_oe}, 18'd0);
    sleep = 1'b0;
  endtask

  task automatic t_pipe;
    drive(OP_WR, 8'h20, 2'b00, DX);
    drive(OP_RD, 8'h20, 2'b00, DX);
    chk("R2 not yet driven", {17'd0, dq_oe}, 18'd0);
    drive(OP_WR, 8'h21, 2'b00, DC);
    chk("R4 pipe read of pending write", dq_out, DC);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    drive(OP_IDLE, 8'h00, 2'b00, DD);
    drive(OP_RD, 8'h21, 2'b00, DH);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    chk("R3 pipe double lag", dq_out, DD);
    drive(OP_WR, 8'h22, 2'b00, DX);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    drive(OP_RD, 8'h22, 2'b00, DE);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    chk("R4 pipe commit same edge", dq_out, DE);
  endtask

  task automatic t_burst_lin;
    logic [17:0] e [4];
    for (int k = 0; k < 4; k++) e[k] = 18'h0_1000 + 18'(k * 18'h111);
    drive(OP_WR, 8'h41, 2'b00, DX);
    drive(OP_ADV, 8'h00, 2'b00, DX);
    drive(OP_ADV, 8'h00, 2'b00, e[0]);
    drive(OP_ADV, 8'h00, 2'b00, e[1]);
    drive(OP_IDLE, 8'h00, 2'b00, e[2]);
    drive(OP_IDLE, 8'h00, 2'b00, e[3]);
    drive(OP_RD, 8'h40, 2'b00, DX);
    drive(OP_IDLE, 8'h00, 2'b00, DX);
    chk("R9 linear wrap word", dq_out, e[3]);
    drive(OP_RD, 8'h41, 2'b00, DX);
    for (int k = 0; k < 4; k++) begin
      drive((k < 3) ? OP_ADV : OP_IDLE, 8'h00, 2'b00, DX);
      chk("R9 R2 linear burst beat", dq_out, e[k]);
    end
  endtask

  task automatic t_burst_ilv;
    logic [17:0] f [4];
    logic [1:0]  lo;
    for (int k = 0; k < 4; k++) f[k] = 18'h2_0000 + 18'(k * 18'h0A5);
    drive(OP_WR, 8'h52, 2'b00, DX);
    drive(OP_ADV, 8'h00, 2'b00, DX);
    drive(OP_ADV, 8'h00, 2'b00, f[0]);
    drive(OP_ADV, 8'h00, 2'b00, f[1]);
    drive(OP_IDLE, 8'h00, 2'b00, f[2]);
    drive(OP_IDLE, 8'h00, 2'b00, f[3]);
    for (int a = 0; a < 4; a++) begin
      drive(OP_RD, 8'h50 + 8'(a), 2'b00, DX);
      drive(OP_IDLE, 8'h00, 2'b00, DX);
      lo = 2'(a) ^ 2'd2;
      chk("R10 interleaved placement", dq_out, f[lo]);
    end
    drive(OP_RD, 8'h53, 2'b00, DX);
    for (int k = 0; k < 4; k++) begin
      drive((k < 3) ? OP_ADV : OP_IDLE, 8'h00, 2'b00, DX);
      lo = (2'd3 ^ 2'(k)) ^ 2'd2;
      chk("R10 interleaved read burst", dq_out, f[lo]);
    end
  endtask

  initial begin
    do_reset(1'b0, 1'b0);
    t_reset();
    t_flow();
    t_mask();
    t_ce();
    t_oe();
    t_sleep();
    do_reset(1'b1, 1'b0);
    t_pipe();
    t_burst_lin();
    do_reset(1'b1, 1'b1);
    t_burst_ilv();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule